// File: doc/BRIEF.md
# Tick-Counted Wake-Pin Debouncer

This block filters two wake-up pins with a debouncer that advances only on a periodic low-frequency tick. The tick comes from a real-time clock and arrives as a one-cycle pulse on `tick_i`. It does not count cycles of the block's own clock. On every tick, each enabled channel samples its pin once. When a pin is seen high on enough consecutive ticks, that channel's status bit latches and the wake-up request asserts. The request stays asserted until software issues a clear.

The required run length comes from a 3-bit period field. A value of zero turns the filter off. Any other value N requires N+1 consecutive active ticks, which gives a range of two to eight ticks. Each channel has its own enable bit. The clear command empties both counters and both status bits together.

Top module: `wake_tick_filter`

## Requirements
- R1: After reset, `status_o` is 2'b00 and `wake_req_o` is 0.
- R2: While `period_i` is 0, no channel sets its status bit, whatever the pins and ticks do.
- R3: With `period_i` = N (1..7) and the channel enabled, status bit k sets on the tick that completes N+1 consecutive ticks with `pin_i[k]` high, and not one tick earlier.
- R4: A tick that finds the pin low restarts that channel's count from zero.
- R5: Pin levels are sampled only in cycles where `tick_i` is 1. Pin levels in other cycles neither advance nor restart a count.
- R6: A channel whose enable bit `chan_en_i[k]` is 0 never sets its status bit.
- R7: A status bit, once set, stays set until a clear. `wake_req_o` is 1 exactly when either status bit is 1.
- R8: `clear_i` = 1 zeroes both counters and both status bits at the next edge. This takes priority over a count reaching its target in the same cycle.
- R9: Channels are independent. `pin_i[0]`/`chan_en_i[0]` drive only `status_o[0]`, and `pin_i[1]`/`chan_en_i[1]` drive only `status_o[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the real-time clock; sampling instant |
| period_i | input | 3 | Period field: 0 = off, N = need N+1 ticks |
| chan_en_i | input | 2 | Per-channel enable, bit k for pin k |
| clear_i | input | 1 | Clear command for counters and status |
| pin_i | input | 2 | Wake pins, active high |
| status_o | output | 2 | Sticky per-channel wake status |
| wake_req_o | output | 1 | Wake-up request, OR of status bits |

## Verification
The bench sweeps every nonzero period. For each one it checks that status stays low after N active ticks and rises on tick N+1. An off-by-one in the target decode would fire a tick early or late. It also drops the pin for exactly one tick in the middle of a run. A counter that failed to restart would then wake too soon.

Other cases toggle the pin only between ticks, catching a design that samples every clock. Further cases fire a clear on the same tick that would complete a run, catching a design where set wins over clear. The last group disables one channel, catching a design that ignores the enable or cross-couples the two channels.

// File: rtl/wake_tick_pkg.sv
package wake_tick_pkg;
  localparam int unsigned PERIOD_W = 3;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CNT_W    = PERIOD_W + 1;
endpackage

// File: rtl/wtf_target.sv
module wtf_target #(
  parameter int unsigned PERIOD_W = 3,
  localparam int unsigned CNT_W = PERIOD_W + 1
) (
  input  logic [PERIOD_W-1:0] period_i,
  output logic                active_o,
  output logic [CNT_W-1:0]    target_o
);
  always_comb begin
    active_o = |period_i;
    target_o = {1'b0, period_i} + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    if (active_o) assert_target_range_R3: assert (target_o >= 2);
  end
endmodule

// File: rtl/wtf_chan.sv
module wtf_chan #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             pin_i,
  input  logic             clear_i,
  output logic             status_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             status_q, status_d;
  logic             upd;

  always_comb begin
    cnt_inc  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    cnt_d    = cnt_q;
    status_d = status_q;
    upd      = clear_i | ~run_i | tick_i;
    if (clear_i) begin
      cnt_d    = '0;
      status_d = 1'b0;
    end else if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (pin_i) begin
        if (cnt_inc >= target_i) begin
          cnt_d    = target_i;
          status_d = 1'b1;
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else if (upd) begin
      cnt_q    <= cnt_d;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!status_q && cnt_q == '0));
  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clear_i) |=> status_q);
  assert_set_only_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !tick_i) |=> !status_q);
  assert_idle_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !run_i) |=> !status_q);
  assert_low_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_i && !pin_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wake_tick_filter.sv
module wake_tick_filter
  import wake_tick_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [NUM_CH-1:0]   chan_en_i,
  input  logic                clear_i,
  input  logic [NUM_CH-1:0]   pin_i,
  output logic [NUM_CH-1:0]   status_o,
  output logic                wake_req_o
);
  logic             filt_active;
  logic [CNT_W-1:0] target;

  wtf_target #(.PERIOD_W(PERIOD_W)) target_i (
    .period_i (period_i),
    .active_o (filt_active),
    .target_o (target)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    wtf_chan #(.CNT_W(CNT_W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .run_i    (filt_active & chan_en_i[k]),
      .target_i (target),
      .pin_i    (pin_i[k]),
      .clear_i  (clear_i),
      .status_o (status_o[k])
    );
  end

  assign wake_req_o = |status_o;

  assert_wake_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> $past(tick_i));
  assert_off_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0 && wake_req_o == 1'b0) |=> !wake_req_o);
endmodule

// File: tb/wake_tick_filter_tb_top.sv
module wake_tick_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] period_i = 3'd0;
  logic [1:0] chan_en_i = 2'b00;
  logic       clear_i = 1'b0;
  logic [1:0] pin_i = 2'b00;
  logic [1:0] status_o;
  logic       wake_req_o;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wake_tick_filter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .period_i(period_i),
    .chan_en_i(chan_en_i), .clear_i(clear_i), .pin_i(pin_i),
    .status_o(status_o), .wake_req_o(wake_req_o)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [1:0] pins);
    @(negedge clk);
    pin_i  = pins;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", {wake_req_o, status_o}, 3'b000);
  endtask

  task automatic t_period_off();
    period_i = 3'd0; chan_en_i = 2'b11;
    for (int i = 0; i < 10; i++) do_tick(2'b11);
    chk("R2", {wake_req_o, status_o}, 3'b000);
  endtask

  task automatic t_thresholds();
    chan_en_i = 2'b01;
    for (int p = 1; p <= 7; p++) begin
      do_clear();
      period_i = p[2:0];
      for (int i = 0; i < p; i++) do_tick(2'b01);
      chk("R3 early", {wake_req_o, status_o}, 3'b000);
      do_tick(2'b01);
      chk("R3 exact", {wake_req_o, status_o}, 3'b101);
    end
  endtask

  task automatic t_restart();
    do_clear();
    period_i = 3'd3; chan_en_i = 2'b01;
    for (int i = 0; i < 3; i++) do_tick(2'b01);
    do_tick(2'b00);
    for (int i = 0; i < 3; i++) do_tick(2'b01);
    chk("R4 restart", {wake_req_o, status_o}, 3'b000);
    do_tick(2'b01);
    chk("R4 complete", {wake_req_o, status_o}, 3'b101);
  endtask

  task automatic t_between_ticks();
    do_clear();
    period_i = 3'd2; chan_en_i = 2'b01;
    @(negedge clk); pin_i = 2'b01;
    repeat (20) @(negedge clk);
    chk("R5 no tick", {wake_req_o, status_o}, 3'b000);
    do_tick(2'b01);
    @(negedge clk); pin_i = 2'b00;
    repeat (5) @(negedge clk);
    do_tick(2'b01);
    do_tick(2'b01);
    chk("R5 gaps ignored", {wake_req_o, status_o}, 3'b101);
  endtask

  task automatic t_enable();
    do_clear();
    period_i = 3'd1; chan_en_i = 2'b10;
    for (int i = 0; i < 4; i++) do_tick(2'b11);
    chk("R6 R9 ch1 only", {wake_req_o, status_o}, 3'b110);
    do_clear();
    chan_en_i = 2'b11;
    do_tick(2'b01); do_tick(2'b01);
    chk("R9 ch0 only", {wake_req_o, status_o}, 3'b101);
  endtask

  task automatic t_sticky();
    for (int i = 0; i < 5; i++) do_tick(2'b00);
    chan_en_i = 2'b00;
    repeat (3) @(negedge clk);
    chk("R7 sticky", {wake_req_o, status_o}, 3'b101);
  endtask

  task automatic t_clear();
    do_clear();
    chk("R8 clear", {wake_req_o, status_o}, 3'b000);
    period_i = 3'd1; chan_en_i = 2'b11;
    do_tick(2'b11);
    @(negedge clk);
    pin_i = 2'b11; tick_i = 1'b1; clear_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; clear_i = 1'b0;
    chk("R8 priority", {wake_req_o, status_o}, 3'b000);
    do_tick(2'b11);
    chk("R8 counter cleared", {wake_req_o, status_o}, 3'b000);
    do_tick(2'b11);
    chk("R8 recount", {wake_req_o, status_o}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period_off();
    t_thresholds();
    t_restart();
    t_between_ticks();
    t_enable();
    t_sticky();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule